// File: doc/BRIEF.md
# Checked System Clock Source Switcher

This block holds the select code that steers the system clock multiplexer among five oscillator and PLL sources. Software writes a 3-bit code. The switch is committed only when the requested source already reports that it is stable. A request to a source that is not ready is refused. The refusal is recorded in a sticky failure flag, and software clears that flag by writing 1 to it.

Four of the sources report stability on their own input pins. The PLL's stability is made inside the block by a settle counter. The counter is clocked by the PLL reference clock and has two selectable lengths. It restarts each time the PLL leaves power-down, and its result is brought back into the system clock domain through a two-flop synchronizer. The analog glitch-free mux and the PLL itself sit outside the block.

The block moves no data stream, so it has no valid/ready handshake. All pins are plain control and status levels. A write is a single-cycle strobe. It is always accepted and has no back-pressure.

Top module: `sysclk_source_switch`

## Requirements
- R1: While reset is asserted and after it is released, `cur_src` is 3'b111 when `boot_hirc` is 1 and 3'b000 when it is 0. `switch_fail` is 0 and `pll_stable` is 0 after reset.
- R2: A `sel_wr` strobe whose target is stable loads `cur_src` with `sel_code` on the next clock edge and clears `switch_fail`. The codes are: 000 high-speed crystal (`hxt_stable`), 001 low-speed crystal (`lxt_stable`), 010 PLL (`pll_stable`), 011 low-speed RC (`lirc_stable`), 111 high-speed RC (`hirc_stable`).
- R3: A `sel_wr` strobe whose target is not stable sets `switch_fail` to 1 on the next edge and leaves `cur_src` unchanged.
- R4: Codes 100, 101 and 110 are always refused. They set `switch_fail` and leave `cur_src` unchanged.
- R5: A `fail_w1c` pulse clears `switch_fail` on the next edge. If `sel_wr` is high in the same cycle, the write's result wins.
- R6: `switch_fail` holds its value across idle cycles. Only a clear or a successful write lowers it.
- R7: `pll_stable` is 0 in the same cycle that `pll_pd` or `pll_out_off` is 1.
- R8: With `pll_long_settle` = 0, `pll_stable` rises about 6144 reference-clock cycles after `pll_pd` falls, and not before.
- R9: With `pll_long_settle` = 1, the settle time is 12288 reference-clock cycles.
- R10: A return of `pll_pd` to 1 during settling restarts the count from zero when `pll_pd` falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_hirc | input | 1 | Configuration input that picks the reset select code (1 gives 111, 0 gives 000) |
| pll_ref_clk | input | 1 | PLL reference clock that drives the settle counter |
| pll_pd | input | 1 | PLL power-down |
| pll_out_off | input | 1 | PLL output disabled |
| pll_long_settle | input | 1 | Settle length select (0 gives 6144 cycles, 1 gives 12288 cycles) |
| hxt_stable | input | 1 | High-speed crystal stable |
| lxt_stable | input | 1 | Low-speed crystal stable |
| lirc_stable | input | 1 | Low-speed RC stable |
| hirc_stable | input | 1 | High-speed RC stable |
| sel_wr | input | 1 | Select write strobe |
| sel_code | input | 3 | Requested source code |
| fail_w1c | input | 1 | Write-1 clear of the failure flag |
| cur_src | output | 3 | Committed source code |
| switch_fail | output | 1 | Sticky switch-failure flag |
| pll_stable | output | 1 | PLL settled and usable |

## Verification
The hardest condition to reach from the ports is a settle window that restarts partway through. A first release of power-down must run long enough that, without a restart, it would already have finished. The bench releases `pll_pd`, counts 3000 reference edges, and pulses power-down. It then checks `pll_stable` at a point past the original deadline but before the new one. The two settle lengths are told apart by sampling at 12000 reference cycles, where only the long mode is still settling.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  typedef enum logic [2:0] {
    SRC_HXT  = 3'b000,
    SRC_LXT  = 3'b001,
    SRC_PLL  = 3'b010,
    SRC_LIRC = 3'b011,
    SRC_HIRC = 3'b111
  } src_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/ssw_sync.sv
module ssw_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = ssw_pkg::SYNC_STAGES,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= {WIDTH{RST_VAL}};
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ssw_pll_settle.sv
module ssw_pll_settle #(
  parameter int SHORT_SETTLE = 6144,
  parameter int LONG_SETTLE  = 12288
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pd_in,
  input  logic long_in,
  output logic locked
);
  localparam int CNT_W = $clog2(LONG_SETTLE + 1);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_SETTLE);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_SETTLE);

  logic             pd_s;
  logic             long_s;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // power-down held high through reset so counting starts only after a real release
  ssw_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(pd_in), .q(pd_s)
  );
  ssw_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_len_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(long_in), .q(long_s)
  );

  assign limit = long_s ? LIM_L : LIM_S;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      if (pd_s)              cnt <= '0;
      else if (cnt < limit)  cnt <= cnt + 1'b1;
      locked <= !pd_s && (cnt >= limit);
    end
  end
endmodule

// File: rtl/ssw_target_check.sv
module ssw_target_check
  import ssw_pkg::*;
(
  input  logic [2:0] code,
  input  logic       hxt_ok,
  input  logic       lxt_ok,
  input  logic       pll_ok,
  input  logic       lirc_ok,
  input  logic       hirc_ok,
  output logic       ok
);
  always_comb begin
    unique case (code)
      SRC_HXT:  ok = hxt_ok;
      SRC_LXT:  ok = lxt_ok;
      SRC_PLL:  ok = pll_ok;
      SRC_LIRC: ok = lirc_ok;
      SRC_HIRC: ok = hirc_ok;
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/sysclk_source_switch.sv
module sysclk_source_switch
  import ssw_pkg::*;
#(
  parameter int SHORT_SETTLE = 6144,
  parameter int LONG_SETTLE  = 12288
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_hirc,
  input  logic       pll_ref_clk,
  input  logic       pll_pd,
  input  logic       pll_out_off,
  input  logic       pll_long_settle,
  input  logic       hxt_stable,
  input  logic       lxt_stable,
  input  logic       lirc_stable,
  input  logic       hirc_stable,
  input  logic       sel_wr,
  input  logic [2:0] sel_code,
  input  logic       fail_w1c,
  output logic [2:0] cur_src,
  output logic       switch_fail,
  output logic       pll_stable
);
  logic lock_ref;
  logic lock_sys;
  logic tgt_ok;

  ssw_pll_settle #(.SHORT_SETTLE(SHORT_SETTLE), .LONG_SETTLE(LONG_SETTLE)) u_settle (
    .ref_clk(pll_ref_clk), .rst_n(rst_n), .pd_in(pll_pd),
    .long_in(pll_long_settle), .locked(lock_ref)
  );

  ssw_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_lock_sync (
    .clk(clk), .rst_n(rst_n), .d(lock_ref), .q(lock_sys)
  );

  // gate with the live controls so a power-down is seen without sync delay
  assign pll_stable = lock_sys && !pll_pd && !pll_out_off;

  ssw_target_check u_check (
    .code(sel_code), .hxt_ok(hxt_stable), .lxt_ok(lxt_stable),
    .pll_ok(pll_stable), .lirc_ok(lirc_stable), .hirc_ok(hirc_stable),
    .ok(tgt_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src     <= boot_hirc ? SRC_HIRC : SRC_HXT;
      switch_fail <= 1'b0;
    end else begin
      if (sel_wr) begin
        switch_fail <= !tgt_ok;
        if (tgt_ok) cur_src <= sel_code;
      end else if (fail_w1c) begin
        switch_fail <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssw_checker.sv
module ssw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_pd,
  input logic       pll_out_off,
  input logic       hxt_stable,
  input logic       lxt_stable,
  input logic       lirc_stable,
  input logic       hirc_stable,
  input logic       sel_wr,
  input logic [2:0] sel_code,
  input logic       fail_w1c,
  input logic [2:0] cur_src,
  input logic       switch_fail,
  input logic       pll_stable
);
  logic want_ok;
  always_comb begin
    case (sel_code)
      3'b000:  want_ok = hxt_stable;
      3'b001:  want_ok = lxt_stable;
      3'b010:  want_ok = pll_stable;
      3'b011:  want_ok = lirc_stable;
      3'b111:  want_ok = hirc_stable;
      default: want_ok = 1'b0;
    endcase
  end

  a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && want_ok) |=> (cur_src == $past(sel_code) && !switch_fail));

  a_r3_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !want_ok) |=> (switch_fail && $stable(cur_src)));

  a_r4_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur_src inside {3'b100, 3'b101, 3'b110}));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_w1c && !sel_wr) |=> !switch_fail);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(switch_fail) |-> $past(sel_wr));

  a_r7_pll_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_pd || pll_out_off) |-> !pll_stable);
endmodule

bind sysclk_source_switch ssw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pll_pd(pll_pd), .pll_out_off(pll_out_off),
  .hxt_stable(hxt_stable), .lxt_stable(lxt_stable), .lirc_stable(lirc_stable),
  .hirc_stable(hirc_stable), .sel_wr(sel_wr), .sel_code(sel_code),
  .fail_w1c(fail_w1c), .cur_src(cur_src), .switch_fail(switch_fail),
  .pll_stable(pll_stable)
);

// File: tb/sim_sysclk_source_switch.sv
`timescale 1ns/1ps
module sim_sysclk_source_switch;
  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic boot_hirc = 1'b0, pll_pd = 1'b1, pll_out_off = 1'b0, pll_long = 1'b0;
  logic hxt = 1'b1, lxt = 1'b0, lirc = 1'b1, hirc = 1'b1;
  logic sel_wr = 1'b0, fail_w1c = 1'b0;
  logic [2:0] sel_code = 3'b000;
  logic [2:0] cur_src;
  logic switch_fail, pll_stable;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  always #5   ref_clk = ~ref_clk;

  sysclk_source_switch u0 (
    .clk(clk), .rst_n(rst_n), .boot_hirc(boot_hirc), .pll_ref_clk(ref_clk),
    .pll_pd(pll_pd), .pll_out_off(pll_out_off), .pll_long_settle(pll_long),
    .hxt_stable(hxt), .lxt_stable(lxt), .lirc_stable(lirc), .hirc_stable(hirc),
    .sel_wr(sel_wr), .sel_code(sel_code), .fail_w1c(fail_w1c),
    .cur_src(cur_src), .switch_fail(switch_fail), .pll_stable(pll_stable)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic boot);
    @(negedge clk);
    rst_n = 1'b0; boot_hirc = boot;
    repeat (3) @(negedge clk);
    check("R1 reset src", cur_src, boot ? 7 : 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release src", cur_src, boot ? 7 : 0);
    check("R1 fail low", switch_fail, 0);
    check("R1 pll low", pll_stable, 0);
  endtask

  task automatic write_sel(logic [2:0] code, logic clr);
    @(negedge clk);
    sel_wr = 1'b1; sel_code = code; fail_w1c = clr;
    @(negedge clk);
    sel_wr = 1'b0; fail_w1c = 1'b0;
  endtask

  task automatic clear_fail();
    @(negedge clk);
    fail_w1c = 1'b1;
    @(negedge clk);
    fail_w1c = 1'b0;
  endtask

  task automatic t_switching();
    write_sel(3'b111, 1'b0);
    check("R2 to hirc", cur_src, 7);  check("R2 fail", switch_fail, 0);
    write_sel(3'b011, 1'b0);
    check("R2 to lirc", cur_src, 3);
    write_sel(3'b001, 1'b0);
    check("R3 lxt refused", cur_src, 3); check("R3 fail set", switch_fail, 1);
    repeat (5) @(negedge clk);
    check("R6 sticky", switch_fail, 1);
    write_sel(3'b000, 1'b0);
    check("R6 cleared by good write", switch_fail, 0); check("R2 to hxt", cur_src, 0);
    write_sel(3'b010, 1'b0);
    check("R3 pll not ready", switch_fail, 1); check("R3 src kept", cur_src, 0);
    clear_fail();
    check("R5 w1c", switch_fail, 0);
  endtask

  task automatic t_illegal();
    for (int c = 4; c <= 6; c++) begin
      write_sel(3'(c), 1'b0);
      check("R4 illegal fail", switch_fail, 1);
      check("R4 illegal src", cur_src, 0);
      clear_fail();
    end
  endtask

  task automatic t_same_cycle();
    write_sel(3'b001, 1'b1);
    check("R5 write wins over clear", switch_fail, 1);
    write_sel(3'b111, 1'b1);
    check("R5 good write with clear", switch_fail, 0);
    check("R5 src", cur_src, 7);
  endtask

  task automatic settle_window(logic lng, int early, int late, string tag);
    pll_long = lng;
    @(negedge clk); pll_pd = 1'b0;
    repeat (early) @(posedge ref_clk);
    @(negedge clk);
    check({tag, " not yet"}, pll_stable, 0);
    repeat (late - early) @(posedge ref_clk);
    @(negedge clk);
    check({tag, " settled"}, pll_stable, 1);
  endtask

  task automatic t_pll_short();
    settle_window(1'b0, 6000, 6200, "R8");
    write_sel(3'b010, 1'b0);
    check("R8 switch to pll", cur_src, 2);
    @(negedge clk); pll_out_off = 1'b1;
    #0.5; check("R7 out off gates", pll_stable, 0);
    @(negedge clk); pll_out_off = 1'b0;
    @(negedge clk); pll_pd = 1'b1;
    #0.5; check("R7 pd gates", pll_stable, 0);
    write_sel(3'b010, 1'b0);
    check("R7 pll refused when down", switch_fail, 1);
    clear_fail();
    repeat (10) @(posedge ref_clk);
  endtask

  task automatic t_pll_long();
    settle_window(1'b1, 12000, 12400, "R9");
    @(negedge clk); pll_pd = 1'b1; pll_long = 1'b0;
    repeat (10) @(posedge ref_clk);
  endtask

  task automatic t_pll_restart();
    @(negedge clk); pll_pd = 1'b0;
    repeat (3000) @(posedge ref_clk);
    @(negedge clk); pll_pd = 1'b1;
    repeat (10) @(posedge ref_clk);
    @(negedge clk); pll_pd = 1'b0;
    repeat (5000) @(posedge ref_clk);
    @(negedge clk);
    check("R10 restarted count", pll_stable, 0);
    repeat (1300) @(posedge ref_clk);
    @(negedge clk);
    check("R10 settled after restart", pll_stable, 1);
  endtask

  initial begin
    do_reset(1'b0);
    t_switching();
    t_illegal();
    t_same_cycle();
    t_pll_short();
    t_pll_long();
    t_pll_restart();
    @(negedge clk); pll_pd = 1'b1;
    do_reset(1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule